// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Block

This block gives one processor core its inter-processor interrupt registers. Other agents, and the core itself, reach it through a simple 32-bit register bus. Each access carries a byte offset, and one access may be presented per cycle. The block keeps a 32-bit pending word and a 32-bit enable mask. It also has two write-only strobe registers: one ORs bits into the pending word and the other removes bits from it. A bank of eight 32-bit mailbox words lets a sender leave a message next to the interrupt.

The interrupt line to the core is a register. It is not a continuous OR of pending AND enabled bits. Only a write to the set strobe can raise it, and only a write to the clear strobe can lower it, each under its own condition. A clear that empties the pending word while the enable mask is zero therefore leaves the line high. The block also pulses two error flags: one for a write to the read-only pending word, and one for any access to an offset it does not decode.

Top module: `ipi_core_regs`

## Requirements
- R1: After reset, the pending word, the enable mask, all eight mailbox words, the interrupt line and both error flags read as zero.
- R2: Only address bits [7:0] select a register. Accesses that differ only in higher address bits reach the same register.
- R3: The pending word sits at offset 0x00 and is read-only. A write there changes nothing and raises `ro_write_err_o` for exactly one cycle, in the cycle after the write.
- R4: A write to the set strobe at 0x08 ORs the write data into the pending word. If the result ANDed with the enable mask is nonzero, the interrupt line goes to 1. Otherwise the line keeps its value.
- R5: A write to the clear strobe at 0x0C clears the pending bits where the write data is 1. The interrupt line goes to 0 only when the resulting pending word is zero and the enable mask is nonzero. Otherwise the line keeps its value, even when the mask is zero.
- R6: Reads of the set strobe (0x08) and the clear strobe (0x0C) return zero, whatever the state.
- R7: Mailbox words occupy byte offsets 0x20 to 0x3C inclusive. The word index is (offset - 0x20) >> 2, so offset 0x21 selects word 0. Each word is read and written in full.
- R8: The enable mask at offset 0x04 reads back the last value written. Writing it never changes the interrupt line.
- R9: A read or write at any other offset returns zero and changes no state. This covers 0x10 to 0x1C, 0x40, 0x44, unaligned offsets below 0x20, and 0x3D and above. Such an access raises `unimp_err_o` for exactly one cycle, in the cycle after the access.
- R10: The interrupt line changes at the clock edge that ends the causing write. During the write cycle it still shows its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (12) | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the read cycle, zero otherwise |
| irq_o | output | 1 | Registered interrupt line to the core |
| ro_write_err_o | output | 1 | One-cycle pulse after a write to the pending word |
| unimp_err_o | output | 1 | One-cycle pulse after an access to an undecoded offset |

## Verification
The raise and lower decisions can land on adjacent clock edges. The lower decision is then computed from a pending word that the preceding set write has only just updated. The bench provokes this with a set write followed, with no gap, by a clear write of the same bit while the mask is nonzero. It requires the line to be high between the two edges and low after the second. A read of the pending word in the cycle right after each write must show the updated value, which confirms that the read path and the interrupt decision see the same state.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  // Register selector produced by the offset decoder
  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_STATUS = 3'd1,
    SEL_ENABLE = 3'd2,
    SEL_SET    = 3'd3,
    SEL_CLEAR  = 3'd4,
    SEL_MBOX   = 3'd5
  } reg_sel_e;

  // Fixed byte offsets of the control words (low address byte only)
  localparam logic [7:0] OFF_PENDING = 8'h00;
  localparam logic [7:0] OFF_ENABLE  = 8'h04;
  localparam logic [7:0] OFF_SET     = 8'h08;
  localparam logic [7:0] OFF_CLEAR   = 8'h0C;

  // Number of address bits that take part in decoding
  localparam int DEC_BITS = 8;

endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int MBOX_BASE  = 32'h20,
  parameter int MBOX_WORDS = 8,
  parameter int IDX_W      = $clog2(MBOX_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  mbox_idx
);

  localparam logic [7:0] MB_LO = MBOX_BASE[7:0];
  localparam logic [7:0] MB_HI = 8'(MBOX_BASE + 4 * (MBOX_WORDS - 1));

  logic [DEC_BITS-1:0] off;
  logic [7:0]          rel;

  // Bits above the decoded byte are deliberately ignored
  logic unused_hi;
  logic unused_rel;

  assign off        = addr[DEC_BITS-1:0];
  assign unused_hi  = ^addr[ADDR_W-1:DEC_BITS];
  assign rel        = off - MB_LO;
  assign mbox_idx   = rel[IDX_W+1:2];
  assign unused_rel = ^{rel[1:0], rel[7:IDX_W+2]};

  always_comb begin
    sel = SEL_NONE;
    if (off == OFF_PENDING) begin
      sel = SEL_STATUS;
    end else if (off == OFF_ENABLE) begin
      sel = SEL_ENABLE;
    end else if (off == OFF_SET) begin
      sel = SEL_SET;
    end else if (off == OFF_CLEAR) begin
      sel = SEL_CLEAR;
    end else if ((off >= MB_LO) && (off <= MB_HI)) begin
      sel = SEL_MBOX;
    end
  end

endmodule

// File: rtl/ipi_status_irq.sv
module ipi_status_irq #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_we,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] pending_o,
  output logic [DATA_W-1:0] enable_o,
  output logic              irq_o
);

  logic [DATA_W-1:0] pend_q, pend_d;
  logic [DATA_W-1:0] en_q, en_d;
  logic              irq_q, irq_d;
  logic              pend_ce, en_ce, irq_ce;
  logic [DATA_W-1:0] pend_or, pend_andn;

  assign pend_or   = pend_q | wdata;
  assign pend_andn = pend_q & ~wdata;

  // Next-state logic
  always_comb begin
    pend_d = pend_q;
    en_d   = en_q;
    irq_d  = irq_q;
    if (en_we) begin
      en_d = wdata;
    end
    if (set_we) begin
      pend_d = pend_or;
      if (|(pend_or & en_q)) begin
        irq_d = 1'b1;
      end
    end
    if (clr_we) begin
      pend_d = pend_andn;
      if ((pend_andn == '0) && (|en_q)) begin
        irq_d = 1'b0;
      end
    end
  end

  assign pend_ce = set_we | clr_we;
  assign en_ce   = en_we;
  assign irq_ce  = set_we | clr_we;

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_ce) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (irq_ce) begin
      irq_q <= irq_d;
    end
  end

  assign pending_o = pend_q;
  assign enable_o  = en_q;
  assign irq_o     = irq_q;

  AST_IRQ_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(set_we)); // R4
  AST_IRQ_FALL_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> $past(clr_we)); // R5
  AST_CLR_EMPTY_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_we) && (pend_q == '0) && (|en_q)) |-> !irq_q); // R5
  AST_EN_WRITE_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_we) && !$past(set_we) && !$past(clr_we)) |-> $stable(irq_q)); // R8
  AST_PEND_GROWS_ONLY_BY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(set_we) |-> ((pend_q & ~$past(pend_q)) == '0)); // R3

endmodule

// File: rtl/ipi_mbox_bank.sv
module ipi_mbox_bank #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  parameter int IDX_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] word_q [WORDS];

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
    logic              word_ce;
    logic [DATA_W-1:0] word_d;

    assign word_ce = we && (idx == IDX_W'(gi));
    assign word_d  = wdata;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[gi] <= '0;
      end else if (word_ce) begin
        word_q[gi] <= word_d;
      end
    end

    AST_MBOX_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(we && (idx == IDX_W'(gi))) |-> $stable(word_q[gi])); // R7
  end

  assign rdata = word_q[idx];

endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
  import ipi_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int MBOX_WORDS = 8,
  parameter int MBOX_BASE  = 32'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              irq_o,
  output logic              ro_write_err_o,
  output logic              unimp_err_o
);

  localparam int IDX_W = $clog2(MBOX_WORDS);

  reg_sel_e          sel;
  logic [IDX_W-1:0]  mbox_idx;
  logic              wr, rd;
  logic              en_we, set_we, clr_we, mbox_we;
  logic [DATA_W-1:0] pending, enable, mbox_rdata;
  logic              ro_err_q, ro_err_d, unimp_q, unimp_d;

  ipi_addr_decode #(
    .ADDR_W    (ADDR_W),
    .MBOX_BASE (MBOX_BASE),
    .MBOX_WORDS(MBOX_WORDS),
    .IDX_W     (IDX_W)
  ) u_dec (
    .addr    (acc_addr),
    .sel     (sel),
    .mbox_idx(mbox_idx)
  );

  assign wr      = acc_valid & acc_write;
  assign rd      = acc_valid & ~acc_write;
  assign en_we   = wr && (sel == SEL_ENABLE);
  assign set_we  = wr && (sel == SEL_SET);
  assign clr_we  = wr && (sel == SEL_CLEAR);
  assign mbox_we = wr && (sel == SEL_MBOX);

  ipi_status_irq #(
    .DATA_W(DATA_W)
  ) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_we    (en_we),
    .set_we   (set_we),
    .clr_we   (clr_we),
    .wdata    (acc_wdata),
    .pending_o(pending),
    .enable_o (enable),
    .irq_o    (irq_o)
  );

  ipi_mbox_bank #(
    .DATA_W(DATA_W),
    .WORDS (MBOX_WORDS),
    .IDX_W (IDX_W)
  ) u_mbox (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mbox_we),
    .idx  (mbox_idx),
    .wdata(acc_wdata),
    .rdata(mbox_rdata)
  );

  // Read multiplexer: strobes and undecoded offsets read as zero
  always_comb begin
    acc_rdata = '0;
    if (rd) begin
      case (sel)
        SEL_STATUS: acc_rdata = pending;
        SEL_ENABLE: acc_rdata = enable;
        SEL_MBOX:   acc_rdata = mbox_rdata;
        default:    acc_rdata = '0;
      endcase
    end
  end

  // Error flag next state
  always_comb begin
    ro_err_d = wr && (sel == SEL_STATUS);
    unimp_d  = acc_valid && (sel == SEL_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ro_err_q <= 1'b0;
      unimp_q  <= 1'b0;
    end else begin
      ro_err_q <= ro_err_d;
      unimp_q  <= unimp_d;
    end
  end

  assign ro_write_err_o = ro_err_q;
  assign unimp_err_o    = unimp_q;

  AST_ERR_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ro_write_err_o, unimp_err_o})); // R9
  AST_RO_WRITE_KEEPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ro_write_err_o |-> $stable(pending)); // R3
  AST_UNIMP_NO_STATE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    unimp_err_o |-> ($stable(pending) && $stable(enable) && $stable(irq_o))); // R9
  AST_STROBE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && ((sel == SEL_SET) || (sel == SEL_CLEAR))) |-> (acc_rdata == '0)); // R6
  AST_IRQ_MOVES_ONLY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq_o) |-> ($past(set_we) || $past(clr_we))); // R10

endmodule

// File: tb/tb_ipi_core_regs.sv
module tb_ipi_core_regs;

  logic        clk;
  logic        rst_n;
  logic        acc_valid;
  logic        acc_write;
  logic [11:0] acc_addr;
  logic [31:0] acc_wdata;
  logic [31:0] acc_rdata;
  logic        irq_o;
  logic        ro_write_err_o;
  logic        unimp_err_o;

  int checks;
  int failures;
  bit done;

  ipi_core_regs dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .acc_addr      (acc_addr),
    .acc_wdata     (acc_wdata),
    .acc_rdata     (acc_rdata),
    .irq_o         (irq_o),
    .ro_write_err_o(ro_write_err_o),
    .unimp_err_o   (unimp_err_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Write: drive for one cycle; returns at the next falling edge, after the edge that took it
  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_wdata = '0;
    #1 d = acc_rdata;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    check("R1 ro_err", {31'd0, ro_write_err_o}, 32'd0);
    check("R1 unimp", {31'd0, unimp_err_o}, 32'd0);
    rd(12'h000, v); check("R1 pending", v, 32'd0);
    rd(12'h004, v); check("R1 enable", v, 32'd0);
    for (int i = 0; i < 8; i++) begin
      rd(12'(32'h20 + 4 * i), v); check("R1 mailbox", v, 32'd0);
    end
  endtask

  task automatic t_set_raise();
    logic [31:0] v;
    wr(12'h004, 32'h0000_00F0);
    check("R8 enable write leaves irq", {31'd0, irq_o}, 32'd0);
    rd(12'h004, v); check("R8 enable readback", v, 32'h0000_00F0);
    wr(12'h008, 32'h0000_0001);
    check("R4 unenabled set keeps irq low", {31'd0, irq_o}, 32'd0);
    rd(12'h000, v); check("R4 pending after set", v, 32'h0000_0001);
    // R10: irq still old during write cycle, new after the edge
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 12'h008; acc_wdata = 32'h0000_0010;
    #1 check("R10 irq old in write cycle", {31'd0, irq_o}, 32'd0);
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    check("R10 irq raised one clock later", {31'd0, irq_o}, 32'd1);
    rd(12'h000, v); check("R4 pending ORed", v, 32'h0000_0011);
  endtask

  task automatic t_clear_rules();
    logic [31:0] v;
    wr(12'h00C, 32'h0000_0001);
    check("R5 clear leaving bits keeps irq", {31'd0, irq_o}, 32'd1);
    rd(12'h000, v); check("R5 pending after partial clear", v, 32'h0000_0010);
    wr(12'h00C, 32'h0000_0010);
    check("R5 empty with mask lowers irq", {31'd0, irq_o}, 32'd0);
    // mask zero case: line stays high after emptying
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h008, 32'h0000_0004);
    check("R4 raise", {31'd0, irq_o}, 32'd1);
    wr(12'h004, 32'h0000_0000);
    check("R8 mask cleared keeps irq", {31'd0, irq_o}, 32'd1);
    wr(12'h00C, 32'h0000_0004);
    check("R5 empty with zero mask keeps irq", {31'd0, irq_o}, 32'd1);
    wr(12'h008, 32'h0000_0008);
    check("R4 set with zero mask keeps irq", {31'd0, irq_o}, 32'd1);
    wr(12'h004, 32'h0000_0001);
    wr(12'h00C, 32'h0000_0008);
    check("R5 empty with mask now lowers", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_readonly();
    logic [31:0] v;
    wr(12'h008, 32'h0000_0100);
    wr(12'h000, 32'hFFFF_FFFF);
    check("R3 ro error pulse", {31'd0, ro_write_err_o}, 32'd1);
    @(negedge clk);
    check("R3 ro error one cycle", {31'd0, ro_write_err_o}, 32'd0);
    rd(12'h000, v); check("R3 pending unchanged", v, 32'h0000_0100);
    rd(12'h008, v); check("R6 set reads zero", v, 32'd0);
    rd(12'h00C, v); check("R6 clear reads zero", v, 32'd0);
    wr(12'h00C, 32'h0000_0100);
  endtask

  task automatic t_mailbox();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) wr(12'(32'h20 + 4 * i), 32'hA500_0000 + 32'(i));
    for (int i = 0; i < 8; i++) begin
      rd(12'(32'h20 + 4 * i), v); check("R7 mailbox word", v, 32'hA500_0000 + 32'(i));
    end
    wr(12'h021, 32'h1234_5678);
    rd(12'h020, v); check("R7 offset 0x21 hits word 0", v, 32'h1234_5678);
    wr(12'h124, 32'hCAFE_0001);
    rd(12'h024, v); check("R2 upper bits ignored on write", v, 32'hCAFE_0001);
    rd(12'hF3C, v); check("R2 upper bits ignored on read", v, 32'hA500_0007);
    wr(12'h304, 32'h0000_0033);
    rd(12'h004, v); check("R2 enable alias", v, 32'h0000_0033);
  endtask

  task automatic t_unimp();
    logic [31:0] v;
    rd(12'h010, v);
    check("R9 undecoded read zero", v, 32'd0);
    check("R9 unimp pulse on read", {31'd0, unimp_err_o}, 32'd1);
    wr(12'h040, 32'hFFFF_FFFF);
    check("R9 unimp pulse 0x40", {31'd0, unimp_err_o}, 32'd1);
    wr(12'h044, 32'hFFFF_FFFF);
    wr(12'h005, 32'hFFFF_FFFF);
    wr(12'h009, 32'hFFFF_FFFF);
    wr(12'h03D, 32'hFFFF_FFFF);
    check("R9 unimp pulse 0x3D", {31'd0, unimp_err_o}, 32'd1);
    @(negedge clk);
    check("R9 unimp one cycle", {31'd0, unimp_err_o}, 32'd0);
    check("R9 irq untouched", {31'd0, irq_o}, 32'd0);
    rd(12'h000, v); check("R9 pending untouched", v, 32'd0);
    rd(12'h004, v); check("R9 enable untouched", v, 32'h0000_0033);
    rd(12'h03C, v); check("R9 last mailbox untouched", v, 32'hA500_0007);
  endtask

  task automatic t_back_to_back();
    logic [31:0] v;
    wr(12'h004, 32'h0000_0001);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 12'h008; acc_wdata = 32'h0000_0001;
    @(negedge clk);
    check("R4 raised between set and clear", {31'd0, irq_o}, 32'd1);
    acc_addr = 12'h00C;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    check("R5 lowered by adjacent clear", {31'd0, irq_o}, 32'd0);
    rd(12'h000, v); check("R5 pending empty after adjacent clear", v, 32'd0);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0; acc_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_raise();
    t_clear_rules();
    t_readonly();
    t_mailbox();
    t_unimp();
    t_back_to_back();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule